// File: doc/BRIEF.md
# Descriptor Cache Flush Controller

This block executes flush commands against a small direct-mapped descriptor cache that it holds internally. A command either targets one line, named by a 40-bit descriptor address whose low bits select the line, or sweeps the entire cache. A flushed line that is present is written back on a one-cycle write-back port. The line is then either invalidated or, in snapshot mode, left valid.

Alongside the cache sits a pool of four blocking slots. A command selects one slot with a 2-bit index. It may release that slot before it runs and may claim it afterwards for the flushed address. While a slot is claimed, the lookup-gate port reports that address as blocked, and the block refuses cache fills to it. If a command misuses a slot, the flush is not executed and the status reports an error.

A whole-cache flush also places the cache in a global blocked state. That state lasts until an unblock command of the whole-cache type arrives. A separate unblock input frees single slots. Before the target line is touched, a command can optionally wait for an external queue-drain engine to finish. A status record echoes the 16-bit command number, but only for commands that request one.

Top module: `desc_flush_ctrl`

## Requirements
- R1: After reset, no status or write-back is produced, no address is blocked, `cmd_ready` is high and `drain_req` is low.
- R2: A single-line flush of a present address writes the line's address and data back once and invalidates it; a flush of an absent address writes nothing back and completes with `st_hit`=0 and no error.
- R3: With `cmd_keep` set, a present line is written back but stays valid, so a repeated flush hits again.
- R4: With `cmd_release` set on a slot that is free, the command is not executed: status has `st_err`=1 and `st_code`=1, no write-back, and the line stays valid.
- R5: With `cmd_block` set on an occupied slot and `cmd_release` clear, no flush happens and status has `st_err`=1 and `st_code`=2.
- R6: With `cmd_block` set and no error, the slot records the address. `q_blocked` is high for that address, and fills to it are refused until the slot is freed. This holds for a missed flush as well.
- R7: `cmd_release` together with `cmd_block` on the same occupied slot frees it and re-claims it for the new address without error.
- R8: `cmd_all` writes back every valid line in ascending index order and invalidates them all. It reports no error and `st_hit`=0, and all other command fields are ignored.
- R9: After a whole-cache flush, `q_blocked` is high for every address and all fills are refused until an unblock with `unb_whole`=1. Slot occupancy is left unchanged.
- R10: With `cmd_drain` set, `drain_req` stays high with no write-back until `drain_done`, and the line is flushed in the following cycle.
- R11: A flush command emits a status pulse carrying `cmd_num` only if `cmd_stat_req` is set; `st_code` encodes 0 none, 1 slot already free, 2 slot busy.
- R12: A single-slot unblock frees an occupied slot with `st_err`=0; on a free slot it returns `st_err`=1, `st_code`=1. Every unblock emits a status carrying `unb_num`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Flush command offered |
| cmd_ready | output | 1 | Flush command accepted this cycle when valid |
| cmd_num | input | 16 | Command number echoed in status |
| cmd_stat_req | input | 1 | Status record wanted |
| cmd_addr | input | 40 | Descriptor address to flush |
| cmd_drain | input | 1 | Wait for queue drain before flushing |
| cmd_release | input | 1 | Free the selected slot first |
| cmd_slot | input | 2 | Blocking slot index |
| cmd_keep | input | 1 | Write back without invalidating |
| cmd_block | input | 1 | Claim the slot for the address after flushing |
| cmd_all | input | 1 | Flush whole cache and block it globally |
| unb_valid | input | 1 | Unblock command offered |
| unb_ready | output | 1 | Unblock accepted this cycle when valid |
| unb_num | input | 16 | Number echoed in unblock status |
| unb_whole | input | 1 | 1: clear global block, 0: free one slot |
| unb_slot | input | 2 | Slot to free |
| fill_valid | input | 1 | Write a line into the cache (idle, unblocked only) |
| fill_addr | input | 40 | Address of the filled line |
| fill_data | input | 32 | Data of the filled line |
| q_addr | input | 40 | Address queried by a cache client |
| q_blocked | output | 1 | Queried address is blocked |
| wb_valid | output | 1 | Write-back beat |
| wb_addr | output | 40 | Written-back line address |
| wb_data | output | 32 | Written-back line data |
| drain_req | output | 1 | Queue drain requested |
| drain_done | input | 1 | Queue drain finished |
| st_valid | output | 1 | Status pulse |
| st_num | output | 16 | Echoed command number |
| st_err | output | 1 | Command failed |
| st_code | output | 2 | Error code |
| st_hit | output | 1 | Flushed address was present |

## Verification
The bench instantiates the default parameters: a 40-bit address, eight lines indexed by the three low address bits, and four slots. With eight lines, a whole-cache sweep finishes in eight write-back cycles. Chosen addresses therefore land on distinct lines even though their upper bits differ widely, which makes both the sweep order and the count of written lines directly observable. The small slot pool means that one slot can be driven through claim, busy, re-claim and release in a short sequence. It also lets another slot stay claimed across a whole-cache flush, which shows that slot state survives it.

// File: rtl/desc_flush_ctrl.sv
module desc_flush_ctrl #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int NUM_W  = 16,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [NUM_W-1:0]  cmd_num,
  input  logic              cmd_stat_req,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_drain,
  input  logic              cmd_release,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic              cmd_keep,
  input  logic              cmd_block,
  input  logic              cmd_all,
  input  logic              unb_valid,
  output logic              unb_ready,
  input  logic [NUM_W-1:0]  unb_num,
  input  logic              unb_whole,
  input  logic [SLOT_W-1:0] unb_slot,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_blocked,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              drain_req,
  input  logic              drain_done,
  output logic              st_valid,
  output logic [NUM_W-1:0]  st_num,
  output logic              st_err,
  output logic [1:0]        st_code,
  output logic              st_hit
);

  localparam int SLOTS = 1 << SLOT_W;
  localparam int IDX_W = $clog2(LINES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);
  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_FREE = 2'd1;
  localparam logic [1:0] ERR_BUSY = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_LINE, S_WALK} state_t;

  state_t             state;
  logic [LINES-1:0]   line_vld;
  logic [ADDR_W-1:0]  line_tag [LINES];
  logic [DATA_W-1:0]  line_dat [LINES];
  logic [SLOTS-1:0]   slot_occ;
  logic [ADDR_W-1:0]  slot_addr [SLOTS];
  logic               gblk;
  logic [IDX_W-1:0]   widx;
  logic [NUM_W-1:0]   c_num;
  logic               c_stat;
  logic [ADDR_W-1:0]  c_addr;
  logic               c_keep;

  logic [SLOTS-1:0] q_match, f_match;
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot_cmp
    assign q_match[i] = slot_occ[i] && (slot_addr[i] == q_addr);
    assign f_match[i] = slot_occ[i] && (slot_addr[i] == fill_addr);
  end

  wire              idle     = (state == S_IDLE);
  wire [IDX_W-1:0]  c_idx    = c_addr[IDX_W-1:0];
  wire [IDX_W-1:0]  f_idx    = fill_addr[IDX_W-1:0];
  wire              cur_vld  = line_vld[c_idx];
  wire              line_hit = cur_vld && (line_tag[c_idx] == c_addr);
  wire              fill_ok  = fill_valid && idle && !gblk && !(|f_match);
  wire              cmd_fire = cmd_valid && cmd_ready;
  wire              unb_fire = unb_valid && unb_ready;
  wire              sel_occ  = slot_occ[cmd_slot];
  wire              rel_bad  = cmd_release && !sel_occ;
  wire              busy_bad = cmd_block && sel_occ && !cmd_release;

  assign unb_ready = idle;
  assign cmd_ready = idle && !unb_valid;
  assign q_blocked = gblk || (|q_match);
  assign drain_req = (state == S_DRAIN);
  assign wb_valid  = ((state == S_LINE) && line_hit) || ((state == S_WALK) && line_vld[widx]);
  assign wb_addr   = (state == S_WALK) ? line_tag[widx] : c_addr;
  assign wb_data   = (state == S_WALK) ? line_dat[widx] : line_dat[c_idx];

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      line_tag[f_idx] <= fill_addr;
      line_dat[f_idx] <= fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_vld <= '0;
    end else begin
      if (fill_ok) line_vld[f_idx] <= 1'b1;
      if (state == S_LINE && line_hit && !c_keep) line_vld[c_idx] <= 1'b0;
      if (state == S_WALK) line_vld[widx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      widx     <= '0;
      gblk     <= 1'b0;
      slot_occ <= '0;
      for (int i = 0; i < SLOTS; i++) slot_addr[i] <= '0;
      c_num    <= '0;
      c_stat   <= 1'b0;
      c_addr   <= '0;
      c_keep   <= 1'b0;
      st_valid <= 1'b0;
      st_num   <= '0;
      st_err   <= 1'b0;
      st_code  <= ERR_NONE;
      st_hit   <= 1'b0;
    end else begin
      st_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (unb_fire) begin
            st_valid <= 1'b1;
            st_num   <= unb_num;
            st_hit   <= 1'b0;
            if (unb_whole) begin
              gblk    <= 1'b0;
              st_err  <= 1'b0;
              st_code <= ERR_NONE;
            end else if (!slot_occ[unb_slot]) begin
              st_err  <= 1'b1;
              st_code <= ERR_FREE;
            end else begin
              slot_occ[unb_slot] <= 1'b0;
              st_err  <= 1'b0;
              st_code <= ERR_NONE;
            end
          end else if (cmd_fire) begin
            c_num  <= cmd_num;
            c_stat <= cmd_stat_req;
            c_addr <= cmd_addr;
            c_keep <= cmd_keep;
            if (cmd_all) begin
              gblk  <= 1'b1;
              widx  <= '0;
              state <= S_WALK;
            end else if (rel_bad || busy_bad) begin
              st_valid <= cmd_stat_req;
              st_num   <= cmd_num;
              st_err   <= 1'b1;
              st_code  <= rel_bad ? ERR_FREE : ERR_BUSY;
              st_hit   <= 1'b0;
            end else begin
              if (cmd_release) slot_occ[cmd_slot] <= 1'b0;
              if (cmd_block) begin
                slot_occ[cmd_slot]  <= 1'b1;
                slot_addr[cmd_slot] <= cmd_addr;
              end
              state <= cmd_drain ? S_DRAIN : S_LINE;
            end
          end
        end
        S_DRAIN: begin
          if (drain_done) state <= S_LINE;
        end
        S_LINE: begin
          state    <= S_IDLE;
          st_valid <= c_stat;
          st_num   <= c_num;
          st_err   <= 1'b0;
          st_code  <= ERR_NONE;
          st_hit   <= line_hit;
        end
        S_WALK: begin
          widx <= widx + 1'b1;
          if (widx == LAST) begin
            state    <= S_IDLE;
            st_valid <= c_stat;
            st_num   <= c_num;
            st_err   <= 1'b0;
            st_code  <= ERR_NONE;
            st_hit   <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_line_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LINE && !c_keep && line_hit) |=> !cur_vld);

  a_r3_line_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LINE && c_keep && line_hit) |=> cur_vld);

  a_r4_error_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_err) |-> !$past(wb_valid));

  a_r9_walk_keeps_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WALK) |=> $stable(slot_occ));

  a_r9_blocked_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WALK && widx == LAST) |=> q_blocked);

  a_r10_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req && !drain_done) |=> drain_req);

  a_r10_no_wb_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> !wb_valid);

  a_r12_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_fire, unb_fire}));

endmodule

// File: tb/desc_flush_ctrl_bench.sv
module desc_flush_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_stat_req = 0, cmd_drain = 0, cmd_release = 0;
  logic        cmd_keep = 0, cmd_block = 0, cmd_all = 0;
  logic [15:0] cmd_num = '0;
  logic [39:0] cmd_addr = '0;
  logic [1:0]  cmd_slot = '0;
  logic        cmd_ready;
  logic        unb_valid = 0, unb_whole = 0, unb_ready;
  logic [15:0] unb_num = '0;
  logic [1:0]  unb_slot = '0;
  logic        fill_valid = 0;
  logic [39:0] fill_addr = '0;
  logic [31:0] fill_data = '0;
  logic [39:0] q_addr = '0;
  logic        q_blocked;
  logic        wb_valid;
  logic [39:0] wb_addr;
  logic [31:0] wb_data;
  logic        drain_req, drain_done = 0;
  logic        st_valid, st_err, st_hit;
  logic [15:0] st_num;
  logic [1:0]  st_code;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_flush_ctrl u_desc_flush_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_num(cmd_num),
    .cmd_stat_req(cmd_stat_req), .cmd_addr(cmd_addr), .cmd_drain(cmd_drain),
    .cmd_release(cmd_release), .cmd_slot(cmd_slot), .cmd_keep(cmd_keep),
    .cmd_block(cmd_block), .cmd_all(cmd_all),
    .unb_valid(unb_valid), .unb_ready(unb_ready), .unb_num(unb_num),
    .unb_whole(unb_whole), .unb_slot(unb_slot),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .q_addr(q_addr), .q_blocked(q_blocked),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .drain_req(drain_req), .drain_done(drain_done),
    .st_valid(st_valid), .st_num(st_num), .st_err(st_err),
    .st_code(st_code), .st_hit(st_hit)
  );

  localparam logic [39:0] ADR [4] = '{40'hAB_0000_0010, 40'h12_3456_7801,
                                      40'h00_0000_0002, 40'hFF_FFFF_FFF3};
  localparam logic [31:0] DAT [4] = '{32'hCAFE_0000, 32'h1111_2222,
                                      32'h3333_4444, 32'h5555_6666};

  // fields: all rel blk keep slot[2] asel[2] | err code[2] hit wb
  localparam logic [12:0] VEC [10] = '{
    13'b0_0_0_0_00_00_0_00_1_1,  // R2 hit
    13'b0_0_0_0_00_00_0_00_0_0,  // R2 miss
    13'b0_0_0_1_00_01_0_00_1_1,  // R3 snapshot
    13'b0_0_0_1_00_01_0_00_1_1,  // R3 still valid
    13'b0_1_0_0_01_01_1_01_0_0,  // R4 release of free slot
    13'b0_0_1_0_10_10_0_00_1_1,  // R6 claim slot 2
    13'b0_0_1_0_10_11_1_10_0_0,  // R5 slot busy
    13'b0_1_1_0_10_11_0_00_1_1,  // R7 release and re-claim
    13'b0_0_0_0_00_10_0_00_0_0,  // R2 line gone
    13'b0_0_0_0_00_01_0_00_1_1   // R4 line untouched by failed command
  };

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_fill(input logic [39:0] a, input logic [31:0] d);
    @(negedge clk);
    fill_valid = 1; fill_addr = a; fill_data = d;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic query(input logic [39:0] a, output logic b);
    q_addr = a;
    #1;
    b = q_blocked;
  endtask

  task automatic run_cmd(input logic all, input logic rel, input logic blk, input logic keep,
                         input logic stat, input logic [1:0] slot, input logic [39:0] a,
                         input logic [15:0] num, output logic got, output logic [15:0] n,
                         output logic e, output logic [1:0] c, output logic h,
                         output int nwb, output logic [39:0] wa, output logic [31:0] wd);
    @(negedge clk);
    cmd_all = all; cmd_release = rel; cmd_block = blk; cmd_keep = keep;
    cmd_stat_req = stat; cmd_slot = slot; cmd_addr = a; cmd_num = num;
    cmd_drain = 0; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    got = 0; n = '0; e = 0; c = '0; h = 0; nwb = 0; wa = '0; wd = '0;
    for (int k = 0; k < 40 && !got; k++) begin
      if (wb_valid) begin
        if (nwb == 0) begin wa = wb_addr; wd = wb_data; end
        nwb++;
      end
      if (st_valid) begin
        got = 1; n = st_num; e = st_err; c = st_code; h = st_hit;
      end
      if (!got) @(negedge clk);
    end
  endtask

  task automatic run_unb(input logic whole, input logic [1:0] slot, input logic [15:0] num,
                         output logic got, output logic [15:0] n, output logic e,
                         output logic [1:0] c);
    @(negedge clk);
    unb_whole = whole; unb_slot = slot; unb_num = num; unb_valid = 1;
    while (!unb_ready) @(negedge clk);
    @(negedge clk);
    unb_valid = 0;
    got = st_valid; n = st_num; e = st_err; c = st_code;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic got, e, h, b, ok;
    logic [15:0] n;
    logic [1:0] c;
    int nwb;
    logic [39:0] wa;
    logic [31:0] wd;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    query(ADR[0], b);
    chk("R1 st_valid", st_valid, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 q_blocked", b, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 drain_req", drain_req, 0);

    for (int i = 0; i < 4; i++) do_fill(ADR[i], DAT[i]);

    for (int i = 0; i < 10; i++) begin
      logic [12:0] v;
      v = VEC[i];
      run_cmd(v[12], v[11], v[10], v[9], 1'b1, v[8:7], ADR[v[6:5]], 16'h100 + 16'(i),
              got, n, e, c, h, nwb, wa, wd);
      chk($sformatf("R11 vec%0d status seen", i), got, 1);
      chk($sformatf("R11 vec%0d number", i), n, 16'h100 + 16'(i));
      chk($sformatf("R4 R5 vec%0d err", i), e, v[4]);
      chk($sformatf("R4 R5 vec%0d code", i), c, v[3:2]);
      chk($sformatf("R2 R3 vec%0d hit", i), h, v[1]);
      chk($sformatf("R2 R7 vec%0d writebacks", i), nwb, v[0]);
      if (v[0]) begin
        chk($sformatf("R2 vec%0d wb addr", i), wa, ADR[v[6:5]]);
        chk($sformatf("R2 vec%0d wb data", i), wd, DAT[v[6:5]]);
      end
    end

    // R6: slot 2 now holds ADR[3]
    query(ADR[3], b); chk("R6 blocked address", b, 1);
    query(ADR[2], b); chk("R6 other address", b, 0);
    do_fill(ADR[3], DAT[3]);
    do_fill(ADR[2], DAT[2]);
    run_cmd(0, 0, 0, 0, 1, 2'd0, ADR[3], 16'h200, got, n, e, c, h, nwb, wa, wd);
    chk("R6 fill to blocked refused", h, 0);
    run_cmd(0, 0, 0, 1, 1, 2'd0, ADR[2], 16'h201, got, n, e, c, h, nwb, wa, wd);
    chk("R6 fill to free address taken", h, 1);

    // R12
    run_unb(0, 2'd2, 16'h210, got, n, e, c);
    chk("R12 unblock status", got, 1);
    chk("R12 unblock number", n, 16'h210);
    chk("R12 unblock ok", e, 0);
    query(ADR[3], b); chk("R12 address released", b, 0);
    run_unb(0, 2'd2, 16'h211, got, n, e, c);
    chk("R12 free slot err", e, 1);
    chk("R12 free slot code", c, 2'd1);

    // R11: no status requested
    run_cmd(0, 0, 0, 1, 0, 2'd0, ADR[2], 16'h220, got, n, e, c, h, nwb, wa, wd);
    chk("R11 no status", got, 0);
    chk("R11 flush still done", nwb, 1);

    // R10: drain handshake
    @(negedge clk);
    cmd_all = 0; cmd_release = 0; cmd_block = 0; cmd_keep = 0; cmd_stat_req = 1;
    cmd_slot = 0; cmd_addr = ADR[2]; cmd_num = 16'h300; cmd_drain = 1; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0; cmd_drain = 0;
    ok = 1;
    for (int k = 0; k < 5; k++) begin
      if (!drain_req || wb_valid || st_valid) ok = 0;
      @(negedge clk);
    end
    chk("R10 waits for drain", ok, 1);
    drain_done = 1;
    @(negedge clk);
    drain_done = 0;
    chk("R10 wb after drain", wb_valid, 1);
    chk("R10 wb addr", wb_addr, ADR[2]);
    @(negedge clk);
    chk("R10 status", st_valid, 1);
    chk("R10 hit", st_hit, 1);
    chk("R10 drain released", drain_req, 0);

    // R6: claim on a miss
    run_cmd(0, 0, 1, 0, 1, 2'd1, ADR[1], 16'h310, got, n, e, c, h, nwb, wa, wd);
    chk("R6 miss no error", e, 0);
    chk("R6 miss reported", h, 0);
    query(ADR[1], b); chk("R6 miss still blocks", b, 1);

    // R8 / R9: whole-cache flush with junk in other fields
    do_fill(ADR[0], DAT[0]);
    do_fill(ADR[2], DAT[2]);
    do_fill(ADR[3], DAT[3]);
    run_cmd(1, 1, 1, 1, 1, 2'd0, ADR[1], 16'h400, got, n, e, c, h, nwb, wa, wd);
    chk("R8 status", got, 1);
    chk("R8 number", n, 16'h400);
    chk("R8 no error", e, 0);
    chk("R8 hit zero", h, 0);
    chk("R8 writeback count", nwb, 3);
    chk("R8 first line index 0", wa, ADR[0]);
    query(40'h77_7777_7777, b); chk("R9 global block", b, 1);
    do_fill(ADR[0], DAT[0]);
    run_unb(1, 2'd0, 16'h401, got, n, e, c);
    chk("R9 whole unblock ok", e, 0);
    query(40'h77_7777_7777, b); chk("R9 global block cleared", b, 0);
    query(ADR[1], b); chk("R9 slot kept", b, 1);
    run_cmd(0, 0, 0, 0, 1, 2'd0, ADR[3], 16'h410, got, n, e, c, h, nwb, wa, wd);
    chk("R8 lines invalidated", h, 0);
    run_cmd(0, 0, 0, 0, 1, 2'd0, ADR[0], 16'h411, got, n, e, c, h, nwb, wa, wd);
    chk("R9 fill refused while blocked", h, 0);
    run_unb(0, 2'd1, 16'h420, got, n, e, c);
    chk("R9 slot 1 still occupied", e, 0);
    run_unb(0, 2'd0, 16'h421, got, n, e, c);
    chk("R8 slot field ignored", c, 2'd1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule